// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two W-bit buses, A and B, and moves data from one to the other in either direction. An active-low transfer enable and a direction input decide which side, if any, the block drives. For each direction a source select chooses between the live value on the opposite bus and a value held in a storage register. The block has two storage registers. One captures the A bus when its capture strobe rises. The other captures the B bus when its own strobe rises. Captures happen whatever the enable, direction or selects are set to.

Each bus appears as three ports: an input carrying the resolved pin value, an output carrying the data the block would drive, and an output-enable. The tri-state pin itself is left to the surrounding wrapper. All logic runs on one system clock. A capture strobe is a level input, and its low-to-high change is detected on that clock. The source mux is built so that changing its select while both sources carry the same bit never disturbs that bit.

Top module: `regd_xcvr`

## Requirements
- R1: While `xfer_en_n` is 1, both `a_oe` and `b_oe` are 0, so the block drives neither bus.
- R2: While `xfer_en_n` is 0, `drive_b` = 0 makes `a_oe` = 1 and `b_oe` = 0. `drive_b` = 1 makes `b_oe` = 1 and `a_oe` = 0.
- R3: `a_out` equals `b_in` in the same cycle, with no clock delay, while `hold_sel_b2a` = 0. It equals the B-to-A storage register while `hold_sel_b2a` = 1.
- R4: `b_out` equals `a_in` in the same cycle while `hold_sel_a2b` = 0. It equals the A-to-B storage register while `hold_sel_a2b` = 1.
- R5: The A-to-B register loads `a_in` at a clock edge where `strb_a2b` is sampled 1 and was sampled 0 at the edge before. Holding the strobe at 1 loads nothing more. The enable, direction and selects have no effect on this load.
- R6: The B-to-A register loads `b_in` on a rising `strb_b2a` in the same way, whatever the enable, direction and selects are.
- R7: A register captures the bus value at its input port even while the block is driving that bus.
- R8: If both strobes rise at the same edge, each register takes the pin value present before that edge. With `hold_sel_a2b` = 1 and B driven, the B-to-A register therefore receives the old A-to-B contents.
- R9: Whenever the live and stored values of a direction are equal, that direction's output equals them, whatever its select is.
- R10: `a_oe` and `b_oe` are never 1 together.
- R11: Reset (`rst_n` = 0) clears both storage registers to zero.
- R12: A stored output changes only at a clock edge on which its register loads. Before that edge it keeps its old value, even if the strobe is already high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xfer_en_n | input | 1 | Active-low transfer enable; high isolates both buses |
| drive_b | input | 1 | 0: block drives bus A; 1: block drives bus B |
| hold_sel_a2b | input | 1 | Source for bus B: 0 live A, 1 stored A-to-B register |
| hold_sel_b2a | input | 1 | Source for bus A: 0 live B, 1 stored B-to-A register |
| strb_a2b | input | 1 | Capture strobe for the A-to-B register (rising change loads) |
| strb_b2a | input | 1 | Capture strobe for the B-to-A register (rising change loads) |
| a_in | input | W | Resolved value present on bus A |
| a_out | output | W | Data offered to bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | W | Resolved value present on bus B |
| b_out | output | W | Data offered to bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The hardest cases to reach are the ones where a register captures a bus that the block is driving itself (R7, R8). In those cases the value captured is a loop-back of the block's own output. The bench resolves each pin procedurally after every stimulus change. When an enable is set, it copies the block's driven data back into the matching input; otherwise it uses the external value. It repeats this until the values settle, so the loop-back is real. For R8 the bench first loads both registers with distinct values. It then drives B from the stored A value and raises both strobes together. Afterwards it reads both registers back through the stored paths.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  localparam int unsigned XCVR_W_DEF = 8;

  typedef enum logic {
    SIDE_A = 1'b0,
    SIDE_B = 1'b1
  } side_e;

  typedef struct packed {
    logic a_oe;
    logic b_oe;
  } drive_t;

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         load
);

  logic         strobe_q;
  logic [W-1:0] data_q;
  logic [W-1:0] data_d;

  // rising change of the strobe, seen on the system clock
  always_comb begin
    load   = strobe & ~strobe_q;
    data_d = data_q;
    if (load) begin
      data_d = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      data_q   <= '0;
    end else begin
      strobe_q <= strobe;
      data_q   <= data_d;
    end
  end

  assign q = data_q;

endmodule

// File: rtl/xcvr_hfree_mux.sv
module xcvr_hfree_mux #(
  parameter int unsigned W = 8
) (
  input  logic         sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] y
);

  // sum-of-products mux with the consensus term: an output bit whose two
  // sources agree is held by (live & stored) while sel changes
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic pick_live;
    logic pick_store;
    logic agree;
    always_comb begin
      pick_live  = ~sel & live[i];
      pick_store = sel & stored[i];
      agree      = live[i] & stored[i];
      y[i]       = pick_live | pick_store | agree;
    end
  end

endmodule

// File: rtl/xcvr_drive_ctrl.sv
module xcvr_drive_ctrl
  import xcvr_pkg::*;
(
  input  logic   xfer_en_n,
  input  side_e  side,
  output drive_t drv
);

  always_comb begin
    drv = '0;
    if (!xfer_en_n) begin
      drv.a_oe = (side == SIDE_A);
      drv.b_oe = (side == SIDE_B);
    end
  end

endmodule

// File: rtl/regd_xcvr.sv
module regd_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W          = XCVR_W_DEF,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         xfer_en_n,
  input  logic         drive_b,
  input  logic         hold_sel_a2b,
  input  logic         hold_sel_b2a,
  input  logic         strb_a2b,
  input  logic         strb_b2a,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);

  logic         rst_q_n;
  logic [W-1:0] a2b_q;
  logic [W-1:0] b2a_q;
  logic         ld_a2b;
  logic         ld_b2a;
  side_e        side;
  drive_t       drv;

  xcvr_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  xcvr_cap_reg #(.W(W)) u_reg_a2b (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .strobe (strb_a2b),
    .d      (a_in),
    .q      (a2b_q),
    .load   (ld_a2b)
  );

  xcvr_cap_reg #(.W(W)) u_reg_b2a (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .strobe (strb_b2a),
    .d      (b_in),
    .q      (b2a_q),
    .load   (ld_b2a)
  );

  xcvr_hfree_mux #(.W(W)) u_mux_to_b (
    .sel    (hold_sel_a2b),
    .live   (a_in),
    .stored (a2b_q),
    .y      (b_out)
  );

  xcvr_hfree_mux #(.W(W)) u_mux_to_a (
    .sel    (hold_sel_b2a),
    .live   (b_in),
    .stored (b2a_q),
    .y      (a_out)
  );

  assign side = drive_b ? SIDE_B : SIDE_A;

  xcvr_drive_ctrl u_ctrl (
    .xfer_en_n (xfer_en_n),
    .side      (side),
    .drv       (drv)
  );

  assign a_oe = drv.a_oe;
  assign b_oe = drv.b_oe;

endmodule

// File: rtl/regd_xcvr_chk.sv
module regd_xcvr_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rst_q_n,
  input logic         xfer_en_n,
  input logic         drive_b,
  input logic         a_oe,
  input logic         b_oe,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic [W-1:0] a2b_q,
  input logic [W-1:0] b2a_q,
  input logic         ld_a2b,
  input logic         ld_b2a
);

  // R1
  iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_en_n |-> (!a_oe && !b_oe));

  // R2
  dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_en_n |-> (a_oe == !drive_b && b_oe == drive_b));

  // R10
  one_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_oe && b_oe));

  // R9
  agree_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_in == b2a_q) |-> (a_out == b_in));

  // R9
  agree_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_in == a2b_q) |-> (b_out == a_in));

  // R12
  hold_a2b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ld_a2b) |-> $stable(a2b_q));

  // R12
  hold_b2a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ld_b2a) |-> $stable(b2a_q));

  // R11
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_q_n |-> (a2b_q == '0 && b2a_q == '0));

endmodule

bind regd_xcvr regd_xcvr_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_q_n   (rst_q_n),
  .xfer_en_n (xfer_en_n),
  .drive_b   (drive_b),
  .a_oe      (a_oe),
  .b_oe      (b_oe),
  .a_in      (a_in),
  .b_in      (b_in),
  .a_out     (a_out),
  .b_out     (b_out),
  .a2b_q     (a2b_q),
  .b2a_q     (b2a_q),
  .ld_a2b    (ld_a2b),
  .ld_b2a    (ld_b2a)
);

// File: tb/regd_xcvr_tb.sv
`timescale 1ns/100ps
module regd_xcvr_tb;

  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic         xfer_en_n;
  logic         drive_b;
  logic         hold_sel_a2b;
  logic         hold_sel_b2a;
  logic         strb_a2b;
  logic         strb_b2a;
  logic [W-1:0] a_in;
  logic [W-1:0] b_in;
  logic [W-1:0] a_out;
  logic [W-1:0] b_out;
  logic         a_oe;
  logic         b_oe;
  logic [W-1:0] a_drv;
  logic [W-1:0] b_drv;

  int checks;
  int failures;
  bit done;

  regd_xcvr #(.W(W)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .xfer_en_n    (xfer_en_n),
    .drive_b      (drive_b),
    .hold_sel_a2b (hold_sel_a2b),
    .hold_sel_b2a (hold_sel_b2a),
    .strb_a2b     (strb_a2b),
    .strb_b2a     (strb_b2a),
    .a_in         (a_in),
    .a_out        (a_out),
    .a_oe         (a_oe),
    .b_in         (b_in),
    .b_out        (b_out),
    .b_oe         (b_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // resolve both pins: the block's data when it drives, external otherwise
  task automatic settle();
    for (int k = 0; k < 3; k++) begin
      #0.1;
      b_in = b_oe ? b_out : b_drv;
      a_in = a_oe ? a_out : a_drv;
    end
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_ctrl(input logic en_n, input logic to_b, input logic hs_ab, input logic hs_ba);
    xfer_en_n    = en_n;
    drive_b      = to_b;
    hold_sel_a2b = hs_ab;
    hold_sel_b2a = hs_ba;
    settle();
  endtask

  task automatic pulse(input logic s_ab, input logic s_ba);
    @(negedge clk);
    strb_a2b = s_ab;
    strb_b2a = s_ba;
    settle();
    @(posedge clk);
    @(negedge clk);
    strb_a2b = 1'b0;
    strb_b2a = 1'b0;
    settle();
  endtask

  task automatic t_reset();
    @(negedge clk);
    set_ctrl(1'b1, 1'b0, 1'b1, 1'b1);
    chk("R1 reset isolation a_oe", {7'd0, a_oe}, 8'h00);
    chk("R1 reset isolation b_oe", {7'd0, b_oe}, 8'h00);
    b_drv = 8'hC3;
    set_ctrl(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R11 b2a register cleared", a_out, 8'h00);
    a_drv = 8'h3C;
    set_ctrl(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R11 a2b register cleared", b_out, 8'h00);
  endtask

  task automatic t_dir();
    @(negedge clk);
    set_ctrl(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2 dir0 a_oe/b_oe", {6'd0, a_oe, b_oe}, 8'h02);
    set_ctrl(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R2 dir1 a_oe/b_oe", {6'd0, a_oe, b_oe}, 8'h01);
    set_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R1 R10 isolation", {6'd0, a_oe, b_oe}, 8'h00);
  endtask

  task automatic t_live();
    @(negedge clk);
    b_drv = 8'h3C;
    set_ctrl(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R3 live B to A", a_out, 8'h3C);
    b_drv = 8'hA5;
    settle();
    chk("R3 live B to A same cycle", a_out, 8'hA5);
    a_drv = 8'h5A;
    set_ctrl(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R4 live A to B", b_out, 8'h5A);
  endtask

  task automatic t_capture();
    set_ctrl(1'b1, 1'b0, 1'b1, 1'b1);
    a_drv = 8'h81;
    b_drv = 8'h42;
    pulse(1'b1, 1'b0);
    set_ctrl(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R5 a2b capture while isolated", b_out, 8'h81);
    set_ctrl(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R6 b2a untouched by a2b strobe", a_out, 8'h00);
    set_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
    pulse(1'b0, 1'b1);
    set_ctrl(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R6 b2a capture", a_out, 8'h42);
    // held strobe: one load only, and no change before the edge
    set_ctrl(1'b0, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    a_drv    = 8'h11;
    strb_a2b = 1'b1;
    settle();
    chk("R12 stored output before edge", b_out, 8'h81);
    @(posedge clk);
    @(negedge clk);
    settle();
    chk("R5 load on rising strobe", b_out, 8'h11);
    a_drv = 8'h22;
    settle();
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    settle();
    chk("R5 held strobe no reload", b_out, 8'h11);
    strb_a2b = 1'b0;
    settle();
  endtask

  task automatic t_self_capture();
    @(negedge clk);
    b_drv = 8'h6E;
    a_drv = 8'hFF;
    set_ctrl(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 A driven with live B", a_in, 8'h6E);
    pulse(1'b1, 1'b0);
    set_ctrl(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R7 a2b captured driven pin", b_out, 8'h6E);
  endtask

  task automatic t_simul();
    a_drv = 8'h99;
    set_ctrl(1'b0, 1'b1, 1'b0, 1'b0);
    pulse(1'b1, 1'b0);
    b_drv = 8'h24;
    set_ctrl(1'b0, 1'b0, 1'b0, 1'b0);
    pulse(1'b0, 1'b1);
    a_drv = 8'h17;
    set_ctrl(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R8 B driven from store", b_out, 8'h99);
    pulse(1'b1, 1'b1);
    chk("R8 a2b took A pin", b_out, 8'h17);
    set_ctrl(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R8 b2a took old a2b", a_out, 8'h99);
    a_drv = 8'h5D;
    set_ctrl(1'b0, 1'b1, 1'b0, 1'b0);
    pulse(1'b1, 1'b1);
    set_ctrl(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R8 live both a2b", b_out, 8'h5D);
    set_ctrl(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R8 live both b2a", a_out, 8'h5D);
  endtask

  task automatic t_agree();
    @(negedge clk);
    b_drv = 8'h5D;
    set_ctrl(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 sel0 equal sources", a_out, 8'h5D);
    hold_sel_b2a = 1'b1;
    #0.1;
    chk("R9 sel rise equal sources", a_out, 8'h5D);
    hold_sel_b2a = 1'b0;
    #0.1;
    chk("R9 sel fall equal sources", a_out, 8'h5D);
    b_drv = 8'h00;
    set_ctrl(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R3 stored differs from live", a_out, 8'h5D);
  endtask

  initial begin
    checks       = 0;
    failures     = 0;
    done         = 1'b0;
    rst_n        = 1'b0;
    xfer_en_n    = 1'b1;
    drive_b      = 1'b0;
    hold_sel_a2b = 1'b0;
    hold_sel_b2a = 1'b0;
    strb_a2b     = 1'b0;
    strb_b2a     = 1'b0;
    a_drv        = '0;
    b_drv        = '0;
    a_in         = '0;
    b_in         = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_dir();
    t_live();
    t_capture();
    t_self_capture();
    t_simul();
    t_agree();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule